// File: doc/BRIEF.md
# Shadowed Four-Channel Pulse-Width Modulator

The block generates one pulse-width modulated output for each of four channels. It counts a 1 MHz enable strobe that arrives on an input, rather than a clock of its own. Each channel has a period count, a high-time count and a small control word. The control word picks a divide-by-1, 2, 4 or 8 step for that channel's counter and can invert the output. Software reaches the three words of each channel through a word-addressed register port.

Writes to the high-time and control words only update shadow copies. Writing the period word takes a snapshot of all three shadow values and arms it. A running channel switches to the armed settings only when its current period ends, so no period ever mixes old and new settings. A period of zero is the off state. When an armed zero goes live, the channel finishes the period it is in and then holds its output low. An idle channel starts on the next reference strobe once a nonzero period is written. The usual order is control first, then high time, then period.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every output is low and every register reads as zero.
- R2: Per channel ch (0..3), the period word is at byte address 0x400+4*ch, the high-time word at 0x420+4*ch and the control word at 0x440+4*ch. Control bits [1:0] select a divide of 2^sel and control bit 5 is the invert flag. A read returns the most recently written (shadow) value, and only those control bits read back. Unmapped addresses read zero.
- R3: A write to the high-time or control word alone changes no output.
- R4: On a running channel, a period write takes effect on the strobe that would begin the next period. Until that strobe the old settings continue unchanged.
- R5: On an idle channel, a nonzero period write takes effect on the next reference strobe, with the count starting at 0 on that strobe.
- R6: Counting from 0 when settings go live, the count advances once per 2^sel strobes and wraps after period-1. The output is high while count < high time and low otherwise. The divider restarts when settings go live.
- R7: A high time at or above the period gives a constant high, and a high time of 0 gives a constant low.
- R8: With the invert flag set, a running channel drives the complement of the R6 waveform.
- R9: Once a committed period of 0 goes live, the output stays low whatever the invert flag, until a nonzero period is committed.
- R10: If several period writes arrive before a boundary, only the last one is applied.
- R11: Writes to one channel never change the output of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1mhz | input | 1 | One-clock 1 MHz reference strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
Each output takes the new value on the same rising edge at which tick_1mhz is sampled high, so the bench holds the strobe for exactly one clock and checks the outputs at the next falling edge. A period write is captured one edge after it is presented. The bench therefore finishes every write before it drives the next strobe, and it counts strobes since the settings went live to know which count each sample belongs to. Reads are combinational, so they are checked a short delay after the address is set, with no strobe in between.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int ADDR_W       = 12;
    localparam int CNT_W        = 16;
    localparam int DIV_W        = 2;
    localparam int PRE_W        = (1 << DIV_W) - 1;
    localparam int CH_IDX_W     = 3;
    localparam int CTRL_INV_BIT = 5;

    // Address bits [11:5] select the bank, [4:2] the channel.
    localparam logic [6:0] BANK_PERIOD = 7'h20;
    localparam logic [6:0] BANK_DUTY   = 7'h21;
    localparam logic [6:0] BANK_CTRL   = 7'h22;

    typedef enum logic [1:0] {
        REG_PERIOD,
        REG_DUTY,
        REG_CTRL,
        REG_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CH_IDX_W-1:0]   ch;
    } reg_sel_t;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic [DIV_W-1:0] div;
        logic             invert;
    } ch_cfg_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.ch   = a[4:2];
        s.kind = REG_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[11:5])
                BANK_PERIOD: s.kind = REG_PERIOD;
                BANK_DUTY:   s.kind = REG_DUTY;
                BANK_CTRL:   s.kind = REG_CTRL;
                default:     s.kind = REG_NONE;
            endcase
        end
        return s;
    endfunction

    // Terminal value of the divider for a given select (2^sel - 1).
    function automatic logic [PRE_W-1:0] presc_last(input logic [DIV_W-1:0] sel);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int b = 0; b < PRE_W; b++) begin
            if (b < int'(sel)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_CH-1:0]    commit,
    output ch_cfg_t              commit_cfg [NUM_CH]
);

    reg_sel_t sel;
    assign sel = decode_addr(reg_addr);

    logic [DATA_W-1:0] rd_part [NUM_CH];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_cfg_t shadow_q;
        logic    hit;
        logic    here;

        assign here = (sel.ch == CH_IDX_W'(i));
        assign hit  = reg_we && (sel.kind != REG_NONE) && here;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
            end else if (hit) begin
                case (sel.kind)
                    REG_PERIOD: shadow_q.period <= reg_wdata[CNT_W-1:0];
                    REG_DUTY:   shadow_q.duty   <= reg_wdata[CNT_W-1:0];
                    REG_CTRL: begin
                        shadow_q.div    <= reg_wdata[DIV_W-1:0];
                        shadow_q.invert <= reg_wdata[CTRL_INV_BIT];
                    end
                    default: ;
                endcase
            end
        end

        // Period write snapshots the other two shadows together with the new period.
        assign commit[i]     = hit && (sel.kind == REG_PERIOD);
        assign commit_cfg[i] = '{period: reg_wdata[CNT_W-1:0],
                                 duty:   shadow_q.duty,
                                 div:    shadow_q.div,
                                 invert: shadow_q.invert};

        always_comb begin
            rd_part[i] = '0;
            if (here) begin
                case (sel.kind)
                    REG_PERIOD: rd_part[i] = DATA_W'(shadow_q.period);
                    REG_DUTY:   rd_part[i] = DATA_W'(shadow_q.duty);
                    REG_CTRL: begin
                        rd_part[i][DIV_W-1:0]    = shadow_q.div;
                        rd_part[i][CTRL_INV_BIT] = shadow_q.invert;
                    end
                    default: rd_part[i] = '0;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            reg_rdata = reg_rdata | rd_part[i];
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             commit,
    input  ch_cfg_t          commit_cfg,
    output logic             pwm_o,
    output logic             live_on,
    output logic             load_o,
    output logic [CNT_W-1:0] live_period
);

    ch_cfg_t          live_q;
    ch_cfg_t          pend_q;
    logic             pend_vld_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;

    logic active;
    logic pre_last;
    logic ptick;
    logic period_end;
    logic load;

    assign active     = (live_q.period != '0);
    assign pre_last   = (pre_q == presc_last(live_q.div));
    assign ptick      = tick && active && pre_last;
    assign period_end = ptick && (cnt_q == live_q.period - 1'b1);
    assign load       = tick && pend_vld_q && (!active || period_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q     <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            cnt_q      <= '0;
            pre_q      <= '0;
        end else begin
            if (commit) begin
                pend_q     <= commit_cfg;
                pend_vld_q <= 1'b1;
            end else if (load) begin
                pend_vld_q <= 1'b0;
            end

            if (load) begin
                live_q <= pend_q;
                cnt_q  <= '0;
                pre_q  <= '0;
            end else if (tick && active) begin
                pre_q <= pre_last ? '0 : pre_q + 1'b1;
                if (ptick) begin
                    cnt_q <= period_end ? '0 : cnt_q + 1'b1;
                end
            end
        end
    end

    assign pwm_o       = active && ((cnt_q < live_q.duty) ^ live_q.invert);
    assign live_on     = active;
    assign load_o      = load;
    assign live_period = live_q.period;

endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1mhz,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]            ch_commit;
    ch_cfg_t                      ch_commit_cfg [NUM_CH];
    logic [NUM_CH-1:0]            ch_load;
    logic [NUM_CH-1:0]            ch_live_on;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_live_period;

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .commit     (ch_commit),
        .commit_cfg (ch_commit_cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        pwm_channel chan_i (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick_1mhz),
            .commit      (ch_commit[i]),
            .commit_cfg  (ch_commit_cfg[i]),
            .pwm_o       (pwm_out[i]),
            .live_on     (ch_live_on[i]),
            .load_o      (ch_load[i]),
            .live_period (ch_live_period[i])
        );
    end

endmodule

// File: rtl/pwm_shadow_ctrl_chk.sv
module pwm_shadow_ctrl_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         tick_1mhz,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0]            ch_commit,
    input logic [NUM_CH-1:0]            ch_load,
    input logic [NUM_CH-1:0]            ch_live_on,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_live_period
);

    a_r2_commit_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_commit));

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick_1mhz |=> $stable(pwm_out));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
            !ch_live_on[i] |-> !pwm_out[i]);

        a_r4_load_on_tick: assert property (@(posedge clk) disable iff (rst)
            ch_load[i] |-> tick_1mhz);

        a_r4_live_changes_on_load: assert property (@(posedge clk) disable iff (rst)
            !ch_load[i] |=> $stable(ch_live_period[i]));
    end

endmodule

bind pwm_shadow_ctrl pwm_shadow_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .tick_1mhz      (tick_1mhz),
    .pwm_out        (pwm_out),
    .ch_commit      (ch_commit),
    .ch_load        (ch_load),
    .ch_live_on     (ch_live_on),
    .ch_live_period (ch_live_period)
);

// File: tb/pwm_shadow_ctrl_tb_top.sv
module pwm_shadow_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1mhz = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // 10 time units per cycle: 100 MHz.
    always #5 clk = ~clk;

    pwm_shadow_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_1mhz (tick_1mhz),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic int a_per(input int ch); return 32'h400 + 4 * ch; endfunction
    function automatic int a_dut(input int ch); return 32'h420 + 4 * ch; endfunction
    function automatic int a_ctl(input int ch); return 32'h440 + 4 * ch; endfunction

    task automatic check_val(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset;
        rst = 1'b1; tick_1mhz = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        reg_addr = 12'(a);
        #1;
        check_val(int'(reg_rdata), exp, tag);
    endtask

    task automatic do_tick;
        @(negedge clk) tick_1mhz = 1'b1;
        @(negedge clk) tick_1mhz = 1'b0;
    endtask

    // Index k counts strobes since the settings went live (the go-live strobe is 0).
    task automatic expect_wave(input int ch, input int n, input int k0, input int p,
                               input int d, input int dv, input int inv, input string tag);
        for (int j = 0; j < n; j++) begin
            int cnt;
            int exp;
            do_tick();
            cnt = ((k0 + j) >> dv) % p;
            exp = ((cnt < d) ? 1 : 0) ^ inv;
            check_val(int'(pwm_out[ch]), exp, tag);
            check_val(int'(pwm_out & ~(4'b1 << ch)), 0, "R11 other channels stay low");
        end
    endtask

    task automatic expect_low(input int ch, input int n, input string tag);
        for (int j = 0; j < n; j++) begin
            do_tick();
            check_val(int'(pwm_out[ch]), 0, tag);
        end
    endtask

    task automatic test_reset;
        apply_reset();
        check_val(int'(pwm_out), 0, "R1 outputs low after reset");
        for (int ch = 0; ch < 4; ch++) begin
            rd_check(a_per(ch), 0, "R1 period reads zero");
            rd_check(a_dut(ch), 0, "R1 duty reads zero");
            rd_check(a_ctl(ch), 0, "R1 control reads zero");
        end
    endtask

    task automatic test_readback;
        apply_reset();
        wr(a_dut(3), 32'h0001_1234);
        wr(a_ctl(3), 32'hFF);
        rd_check(a_dut(3), 32'h1234, "R2 duty shadow readback");
        rd_check(a_ctl(3), 32'h23, "R2 control readback keeps bits 1:0 and 5");
        rd_check(a_per(3), 0, "R2 period untouched");
        rd_check(32'h460, 0, "R2 unmapped address reads zero");
        rd_check(32'h421, 0, "R2 unaligned address reads zero");
        check_val(int'(pwm_out), 0, "R3 shadow writes leave outputs low");
        expect_low(3, 4, "R3 no output without period write");
        wr(a_per(3), 7);
        rd_check(a_per(3), 7, "R2 period shadow readback");
    endtask

    task automatic test_basic;
        apply_reset();
        wr(a_ctl(0), 0);
        wr(a_dut(0), 1);
        wr(a_per(0), 4);
        check_val(int'(pwm_out[0]), 0, "R5 not live before strobe");
        expect_wave(0, 8, 0, 4, 1, 0, 0, "R5 R6 idle start period 4 duty 1");
    endtask

    task automatic test_prescale;
        apply_reset();
        wr(a_ctl(1), 2);
        wr(a_dut(1), 2);
        wr(a_per(1), 3);
        expect_wave(1, 24, 0, 3, 2, 2, 0, "R6 divide by 4 period 3 duty 2");
        apply_reset();
        wr(a_ctl(1), 1);
        wr(a_dut(1), 1);
        wr(a_per(1), 2);
        expect_wave(1, 12, 0, 2, 1, 1, 0, "R6 divide by 2 period 2 duty 1");
    endtask

    task automatic test_commit;
        apply_reset();
        wr(a_dut(0), 2);
        wr(a_per(0), 4);
        expect_wave(0, 6, 0, 4, 2, 0, 0, "R6 old settings");
        wr(a_dut(0), 3);
        expect_wave(0, 1, 6, 4, 2, 0, 0, "R3 duty write alone is shadowed");
        wr(a_per(0), 6);
        expect_wave(0, 1, 7, 4, 2, 0, 0, "R4 old settings until boundary");
        expect_wave(0, 12, 0, 6, 3, 0, 0, "R4 new settings from boundary");
    endtask

    task automatic test_latest_wins;
        apply_reset();
        wr(a_dut(2), 1);
        wr(a_per(2), 5);
        expect_wave(2, 2, 0, 5, 1, 0, 0, "R6 start period 5");
        wr(a_dut(2), 2);
        wr(a_per(2), 8);
        wr(a_per(2), 3);
        expect_wave(2, 3, 2, 5, 1, 0, 0, "R4 finish running period");
        expect_wave(2, 6, 0, 3, 2, 0, 0, "R10 last period write applied");
    endtask

    task automatic test_limits;
        apply_reset();
        wr(a_dut(1), 9);
        wr(a_per(1), 5);
        expect_wave(1, 5, 0, 5, 9, 0, 0, "R7 duty above period constant high");
        wr(a_dut(1), 5);
        wr(a_per(1), 5);
        expect_wave(1, 5, 0, 5, 9, 0, 0, "R7 constant high across boundary");
        expect_wave(1, 5, 0, 5, 5, 0, 0, "R7 duty equal period constant high");
        wr(a_dut(1), 0);
        wr(a_per(1), 5);
        expect_wave(1, 10, 0, 5, 0, 0, 0, "R7 duty zero constant low");
    endtask

    task automatic test_invert;
        apply_reset();
        wr(a_ctl(2), 32'h20);
        wr(a_dut(2), 1);
        do_tick();
        check_val(int'(pwm_out[2]), 0, "R9 idle with invert stays low");
        wr(a_per(2), 4);
        expect_wave(2, 8, 0, 4, 1, 0, 1, "R8 inverted waveform");
    endtask

    task automatic test_disable;
        apply_reset();
        wr(a_ctl(3), 32'h21);
        wr(a_dut(3), 1);
        wr(a_per(3), 3);
        expect_wave(3, 4, 0, 3, 1, 1, 1, "R8 inverted divide by 2");
        wr(a_per(3), 0);
        expect_wave(3, 2, 4, 3, 1, 1, 1, "R9 running period completes");
        expect_low(3, 8, "R9 low after disable despite invert");
        rd_check(a_per(3), 0, "R2 period reads zero after disable");
        wr(a_per(3), 3);
        expect_wave(3, 6, 0, 3, 1, 1, 1, "R5 restart from idle");
    endtask

    task automatic print_summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R1..): actual running expected finished");
            print_summary();
            $finish;
        end
    end

    initial begin
        test_reset();
        test_readback();
        test_basic();
        test_prescale();
        test_commit();
        test_latest_wins();
        test_limits();
        test_invert();
        test_disable();
        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule